// File: doc/BRIEF.md
# Time-Slotted Bus Window Scheduler

This block lets one master and many slaves share a two-wire bus with no arbitration or handshake. The master sends a single-cycle sync pulse once per second. Each node counts clock cycles from that pulse, and the count divides the second into equal windows. Window `k` belongs to the slave whose address is `k`. A slave instance raises a transmit permit only inside its own window. A guard band at both edges of the window keeps the permit low so that clock drift between nodes cannot cause an overlap. A master instance uses the same counter to report which slave index owns the bus at present.

Window length comes from a prescaler, `CLK_HZ / SLOTS_PER_SEC` cycles, which is 10 ms with the default parameters. Window 0 opens on the cycle after the sync pulse. When the last window of the second has passed, the bus has no owner until the next pulse. If no pulse arrives within `LOSS_SLOTS` windows (110, or 1.1 s, by default), the node treats sync as lost and withholds every permit until the next pulse. All pins are plain level control and status signals. No data stream passes through the block, so there is no valid/ready interface and no back-pressure.

Top module: `slot_scheduler`

## Requirements
- R1: In the cycle after `sync_i` is sampled high, `owner_valid_o` is 1, `owner_idx_o` is 0 and `sync_lost_o` is 0. This cycle is offset 0 of window 0.
- R2: While the elapsed cycle count `e` since the last sync is below `SLOTS_PER_SEC*SLOT_CYC`, `owner_valid_o` is 1 and `owner_idx_o` equals `e / SLOT_CYC`, where `SLOT_CYC = CLK_HZ/SLOTS_PER_SEC`.
- R3: `tx_permit_o` is 1 only while `owner_idx_o` equals `my_addr_i` and `owner_valid_o` is 1.
- R4: Inside the own window, `tx_permit_o` is 0 for the first `GUARD_CYC` cycles and the last `GUARD_CYC` cycles, and 1 for every offset between them.
- R5: An address of `SLOTS_PER_SEC` or more never receives a permit.
- R6: Once all `SLOTS_PER_SEC` windows have elapsed and no new sync has arrived, `owner_valid_o` is 0 and `owner_idx_o` is 0.
- R7: When `e` reaches `LOSS_SLOTS*SLOT_CYC` with no new sync, `sync_lost_o` goes to 1 and the permit and `owner_valid_o` stay 0 until the next sync pulse.
- R8: After reset and before the first sync pulse, `sync_lost_o` is 1, `tx_permit_o` is 0, `owner_valid_o` is 0 and `owner_idx_o` is 0.
- R9: A sync pulse that arrives in the middle of a window realigns the node at once, so the next cycle is offset 0 of window 0. Back-to-back pulses hold the node at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Once-per-second sync pulse from the master, one cycle wide |
| my_addr_i | input | ADDR_W | Address of this node, which selects the window it owns |
| tx_permit_o | output | 1 | This node may drive the bus |
| owner_idx_o | output | ADDR_W | Index of the window now running (0 when no owner) |
| owner_valid_o | output | 1 | A window of the current second is running |
| sync_lost_o | output | 1 | No valid sync (after reset, or past the loss timeout) |

## Verification
The bench builds the block with `CLK_HZ=100`, `SLOTS_PER_SEC=5`, `GUARD_CYC=3`, `LOSS_SLOTS=6` and `ADDR_W=3`. This gives 20-cycle windows and a 100-cycle frame, and the loss timeout falls 120 cycles after a pulse. With these values a few hundred cycles cover every window edge, both guard bands, the ownerless tail, the loss timeout and its recovery. Addresses 6 and 7 fit in the port but lie beyond the last window, so the never-permitted case can be driven directly.

// File: rtl/slot_pkg.sv
package slot_pkg;
  // Where the node stands within the current second.
  typedef enum logic [1:0] {
    PH_UNSYNCED = 2'd0,  // no pulse since reset, or timed out
    PH_ACTIVE   = 2'd1,  // inside one of the owned windows
    PH_TAIL     = 2'd2   // past the last window, waiting for the next pulse
  } frame_phase_e;
endpackage

// File: rtl/slot_prescaler.sv
module slot_prescaler #(
  parameter int SLOT_CYC = 20,
  parameter int PRE_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  output logic [PRE_W-1:0] pos_o,
  output logic             step_o
);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(SLOT_CYC - 1);

  logic [PRE_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              pos_q <= '0;
    else if (restart_i)      pos_q <= '0;
    else if (pos_q == LAST)  pos_q <= '0;
    else                     pos_q <= pos_q + 1'b1;
  end

  assign pos_o  = pos_q;
  assign step_o = !restart_i && (pos_q == LAST);
endmodule

// File: rtl/slot_frame_counter.sv
module slot_frame_counter
  import slot_pkg::*;
#(
  parameter int SLOTS_PER_SEC = 100,
  parameter int LOSS_SLOTS    = 110,
  parameter int CNT_W         = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] slot_o,
  output frame_phase_e     phase_o
);
  localparam logic [CNT_W-1:0] SAT      = CNT_W'(LOSS_SLOTS);
  localparam logic [CNT_W-1:0] LOSS_PRE = CNT_W'(LOSS_SLOTS - 1);
  localparam logic [CNT_W-1:0] N_SLOTS  = CNT_W'(SLOTS_PER_SEC);

  logic [CNT_W-1:0] slot_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       slot_q <= '0;
    else if (restart_i)               slot_q <= '0;
    else if (step_i && slot_q != SAT) slot_q <= slot_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            seen_q <= 1'b0;
    else if (restart_i)                    seen_q <= 1'b1;
    else if (step_i && slot_q == LOSS_PRE) seen_q <= 1'b0;
  end

  always_comb begin
    if (!seen_q)                phase_o = PH_UNSYNCED;
    else if (slot_q < N_SLOTS)  phase_o = PH_ACTIVE;
    else                        phase_o = PH_TAIL;
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/slot_gate.sv
module slot_gate
  import slot_pkg::*;
#(
  parameter int SLOT_CYC  = 20,
  parameter int GUARD_CYC = 3,
  parameter int PRE_W     = 5,
  parameter int CNT_W     = 7,
  parameter int ADDR_W    = 7
) (
  input  frame_phase_e      phase_i,
  input  logic [CNT_W-1:0]  slot_i,
  input  logic [PRE_W-1:0]  pos_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              permit_o
);
  localparam logic [PRE_W-1:0] OPEN_AT  = PRE_W'(GUARD_CYC);
  localparam logic [PRE_W-1:0] CLOSE_AT = PRE_W'(SLOT_CYC - GUARD_CYC);

  logic addr_hit;
  logic in_body;

  assign addr_hit = (int'(slot_i) == int'(addr_i));
  assign in_body  = (pos_i >= OPEN_AT) && (pos_i < CLOSE_AT);
  assign permit_o = (phase_i == PH_ACTIVE) && addr_hit && in_body;
endmodule

// File: rtl/slot_scheduler.sv
module slot_scheduler
  import slot_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int SLOTS_PER_SEC = 100,
  parameter int GUARD_CYC     = 1000,
  parameter int LOSS_SLOTS    = 110,
  parameter int ADDR_W        = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [ADDR_W-1:0] my_addr_i,
  output logic              tx_permit_o,
  output logic [ADDR_W-1:0] owner_idx_o,
  output logic              owner_valid_o,
  output logic              sync_lost_o
);
  localparam int SLOT_CYC = CLK_HZ / SLOTS_PER_SEC;
  localparam int PRE_W    = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int CNT_W    = $clog2(LOSS_SLOTS + 1);

  logic [PRE_W-1:0] pos;
  logic             step;
  logic [CNT_W-1:0] slot;
  frame_phase_e     phase;

  slot_prescaler #(
    .SLOT_CYC(SLOT_CYC), .PRE_W(PRE_W)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .restart_i(sync_i), .pos_o(pos), .step_o(step)
  );

  slot_frame_counter #(
    .SLOTS_PER_SEC(SLOTS_PER_SEC), .LOSS_SLOTS(LOSS_SLOTS), .CNT_W(CNT_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .restart_i(sync_i), .step_i(step),
    .slot_o(slot), .phase_o(phase)
  );

  slot_gate #(
    .SLOT_CYC(SLOT_CYC), .GUARD_CYC(GUARD_CYC), .PRE_W(PRE_W),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_gate (
    .phase_i(phase), .slot_i(slot), .pos_i(pos), .addr_i(my_addr_i),
    .permit_o(tx_permit_o)
  );

  assign owner_valid_o = (phase == PH_ACTIVE);
  assign owner_idx_o   = owner_valid_o ? ADDR_W'(slot) : '0;
  assign sync_lost_o   = (phase == PH_UNSYNCED);
endmodule

// File: rtl/slot_scheduler_chk.sv
module slot_scheduler_chk #(
  parameter int SLOTS_PER_SEC = 100,
  parameter int GUARD_CYC     = 1000,
  parameter int ADDR_W        = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_i,
  input logic [ADDR_W-1:0] my_addr_i,
  input logic              tx_permit_o,
  input logic [ADDR_W-1:0] owner_idx_o,
  input logic              owner_valid_o,
  input logic              sync_lost_o
);
  logic              armed_q;
  logic              prev_valid_q;
  logic              prev_sync_q;
  logic [ADDR_W-1:0] prev_idx_q;
  int                run_q;
  int                run_now;
  logic              fresh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q      <= 1'b0;
      prev_valid_q <= 1'b0;
      prev_sync_q  <= 1'b0;
      prev_idx_q   <= '0;
      run_q        <= 0;
    end else begin
      armed_q      <= 1'b1;
      prev_valid_q <= owner_valid_o;
      prev_sync_q  <= sync_i;
      prev_idx_q   <= owner_idx_o;
      run_q        <= run_now;
    end
  end

  assign fresh   = !prev_valid_q || prev_sync_q || (owner_idx_o != prev_idx_q);
  assign run_now = fresh ? 0 : run_q + 1;

  AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> owner_valid_o && owner_idx_o == '0 && !sync_lost_o); // R1

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && owner_valid_o && prev_valid_q && !prev_sync_q) |->
      (owner_idx_o == prev_idx_q || owner_idx_o == prev_idx_q + 1'b1)); // R2

  AST_PERMIT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit_o |-> owner_valid_o && owner_idx_o == my_addr_i); // R3

  AST_GUARD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && tx_permit_o) |-> run_now >= GUARD_CYC); // R4

  AST_HIGH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(my_addr_i) >= SLOTS_PER_SEC) |-> !tx_permit_o); // R5

  AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost_o |-> !tx_permit_o && !owner_valid_o); // R7

  AST_NO_OWNER_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    !owner_valid_o |-> owner_idx_o == '0); // R6
endmodule

bind slot_scheduler slot_scheduler_chk #(
  .SLOTS_PER_SEC(SLOTS_PER_SEC), .GUARD_CYC(GUARD_CYC), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .my_addr_i(my_addr_i),
  .tx_permit_o(tx_permit_o), .owner_idx_o(owner_idx_o),
  .owner_valid_o(owner_valid_o), .sync_lost_o(sync_lost_o)
);

// File: tb/slot_scheduler_test.sv
module slot_scheduler_test;
  localparam int CLK_HZ = 100;
  localparam int NSLOT  = 5;
  localparam int GUARD  = 3;
  localparam int LOSS   = 6;
  localparam int AW     = 3;
  localparam int SC     = CLK_HZ / NSLOT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_i = 1'b0;
  logic [AW-1:0] my_addr = '0;
  logic          permit, valid, lost;
  logic [AW-1:0] idx;

  int tests = 0;
  int fails = 0;
  int elapsed = -1;
  bit mid_sync = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slot_scheduler #(
    .CLK_HZ(CLK_HZ), .SLOTS_PER_SEC(NSLOT), .GUARD_CYC(GUARD),
    .LOSS_SLOTS(LOSS), .ADDR_W(AW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .my_addr_i(my_addr),
    .tx_permit_o(permit), .owner_idx_o(idx), .owner_valid_o(valid),
    .sync_lost_o(lost)
  );

  // Reference model: elapsed cycles since the last sampled pulse.
  always @(posedge clk) begin
    if (!rst_n) begin
      elapsed  = -1;
      mid_sync = 1'b0;
    end else if (sync_i) begin
      mid_sync = (elapsed > 0 && elapsed < NSLOT * SC);
      elapsed  = 0;
    end else if (elapsed >= 0 && elapsed < LOSS * SC) begin
      elapsed = elapsed + 1;
    end
  end

  function automatic string tag_for(int e, int a);
    if (e < 0)               return "R8";
    if (e >= LOSS * SC)      return "R7";
    if (e >= NSLOT * SC)     return "R6";
    if (e == 0)              return mid_sync ? "R9" : "R1";
    if (a >= NSLOT)          return "R5";
    if (e / SC == a && ((e % SC) < GUARD || (e % SC) >= SC - GUARD)) return "R4";
    return "R3";
  endfunction

  task automatic check(string what, string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d (elapsed %0d)", req, what, act, exp, elapsed);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit e_lost  = (elapsed < 0) || (elapsed >= LOSS * SC);
      automatic int e_slot  = (elapsed < 0) ? 0 : elapsed / SC;
      automatic bit e_valid = !e_lost && e_slot < NSLOT;
      automatic int e_off   = (elapsed < 0) ? 0 : elapsed % SC;
      automatic bit e_perm  = e_valid && e_slot == int'(my_addr) &&
                              e_off >= GUARD && e_off < SC - GUARD;
      automatic string t    = tag_for(elapsed, int'(my_addr));
      check("sync_lost", e_lost ? ((elapsed < 0) ? "R8" : "R7") : t, int'(lost), int'(e_lost));
      check("owner_valid", e_valid ? "R2" : t, int'(valid), int'(e_valid));
      check("owner_idx", e_valid ? "R2" : t, int'(idx), e_valid ? e_slot : 0);
      check("tx_permit", t, int'(permit), int'(e_perm));
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); sync_i = 1'b1;
    @(negedge clk); sync_i = 1'b0;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #300000;
    fails++;
    $display("FAIL watchdog: run did not end, got hang expected completion");
    finish_up();
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    run(5);                         // R8: idle before first pulse
    my_addr = 3'd2;
    pulse();                        // R1, R2, R3, R4 over a full frame
    run(NSLOT * SC + 30);           // R6 tail, then R7 timeout
    run(10);                        // R7 stays lost
    my_addr = 3'd0;
    pulse();                        // recovery, own window is window 0
    run(30);
    pulse();                        // R9 mid-window realign
    run(45);
    @(negedge clk); sync_i = 1'b1;  // R9 back-to-back pulses
    run(3);
    sync_i = 1'b0;
    run(25);
    my_addr = 3'd4;                 // last window
    pulse();
    run(NSLOT * SC + 5);
    my_addr = 3'd6;                 // R5 beyond the frame
    pulse();
    run(NSLOT * SC + 10);
    my_addr = 3'd7;                 // R5
    pulse();
    run(LOSS * SC + 5);
    finish_up();
  end
endmodule